// File: doc/BRIEF.md
# Transceiver Management Register Access Controller

This controller sits on the transceiver's configuration clock and lets user logic read and write registers in the management register space of a multi-lane transceiver. User logic sends one request at a time over a request/ready handshake. Each request carries a lane number, a device (MMD) address, a register address and, for writes, the data. The controller copies these fields onto the management bus and raises a one-cycle read or write strobe. It keeps every field unchanged until the matching acknowledge arrives. For a read, it returns the acknowledged data to the user as a registered value with a one-cycle valid pulse.

The controller also drives the interface-select output. This output is low while the transceiver is still initializing, which gives the register bus to the reconfiguration port. It goes high once the initialization-done input is seen high. After every change of this output the controller waits a settling window of two cycles before it takes a request. If the acknowledge for an access never arrives, a timeout counter ends the access and sets a sticky error flag, which only reset clears.

Top module: `mgmt_access_ctrl`

## Requirements
- R1: `ifaceSel` is 0 from reset until `initDone` is sampled high. It becomes 1 in the cycle after that sample. If `initDone` is sampled low while the controller is settling or idle, `ifaceSel` returns to 0 in the next cycle.
- R2: `userReady` is 0 during reset, while `ifaceSel` is 0, and while `initDone` is 0. It first becomes 1 exactly two cycles after `ifaceSel` rises, so no strobe appears sooner than two cycles after a change of `ifaceSel`.
- R3: A request accepted with `userWrite`=0 (`userReq` and `userReady` both high at a clock edge) produces `mgmtRdStrobe`=1 in the next cycle and only in that cycle. In that cycle `mgmtLane`, `mgmtMmd` and `mgmtRegAddr` equal the request's fields.
- R4: A request accepted with `userWrite`=1 produces `mgmtWrStrobe`=1 for exactly one cycle in the next cycle. In that cycle the address fields and `mgmtWrData` equal the request. The two strobes are never high together.
- R5: From the strobe until the acknowledge, the management fields stay stable, `userReady` stays 0 and no further strobe is issued. The user request inputs are ignored during this time.
- R6: When `mgmtRdAck` is 1 during a pending read, the cycle after it has `rdValid`=1, `rdData` equal to `mgmtRdData` as sampled with the acknowledge, and `userReady`=1. In every other cycle `rdValid` is 0 and `rdData` is 0.
- R7: When `mgmtWrAck` is 1 during a pending write, the write completes: `userReady` is 1 in the next cycle and `rdValid` stays 0.
- R8: If no matching acknowledge arrives within TIMEOUT_CYCLES cycles, counted from the strobe cycle, the access is abandoned. `userReady` returns to 1 and `errTimeout` becomes 1 in cycle TIMEOUT_CYCLES after the strobe, and no `rdValid` pulse is produced.
- R9: An acknowledge that arrives with no access pending, or that does not match the pending access type, is ignored. It produces no `rdValid` pulse and does not change `userReady`.
- R10: Once `errTimeout` is set it stays 1 until `rst_n` is asserted. Reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| initDone | input | 1 | Transceiver initialization finished |
| ifaceSel | output | 1 | 0 selects the reconfiguration port, 1 selects the management interface |
| userReq | input | 1 | User access request |
| userWrite | input | 1 | 1 for write, 0 for read |
| userLane | input | 4 | Requested lane |
| userMmd | input | 5 | Requested device address |
| userRegAddr | input | 16 | Requested register address |
| userWrData | input | 16 | Write data |
| userReady | output | 1 | Controller can accept a request this cycle |
| rdValid | output | 1 | One-cycle pulse: read data valid |
| rdData | output | 16 | Read data, zero when rdValid is 0 |
| errTimeout | output | 1 | Sticky timeout flag |
| mgmtLane | output | 4 | Lane select to the transceiver |
| mgmtMmd | output | 5 | Device address to the transceiver |
| mgmtRegAddr | output | 16 | Register address to the transceiver |
| mgmtWrData | output | 16 | Write data to the transceiver |
| mgmtRdStrobe | output | 1 | One-cycle read strobe |
| mgmtWrStrobe | output | 1 | One-cycle write strobe |
| mgmtRdAck | input | 1 | Read acknowledge |
| mgmtWrAck | input | 1 | Write acknowledge |
| mgmtRdData | input | 16 | Read data that comes with the read acknowledge |

## Verification
The assertions check, on every cycle, the properties that can be stated locally:
- the select rises only after initialization-done was seen high;
- no strobe appears within two cycles of a select change;
- strobes are single-cycle, mutually exclusive, and always follow an accepted request;
- the management fields stay stable while an access is pending;
- a read-valid pulse always follows a read acknowledge;
- the error flag never falls outside reset.

Some behaviours can only be shown by the bench's scenarios:
- the exact cycle in which ready returns after settling, after an acknowledge and after a timeout;
- the value the read data takes;
- that stray or mismatched acknowledges and user input changes during a pending access leave the outputs unchanged;
- that reset clears the error flag.

// File: rtl/mgmt_access_pkg.sv
package mgmt_access_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_INIT_WAIT,
    ST_SETTLE,
    ST_IDLE,
    ST_READ_WAIT,
    ST_WRITE_WAIT
  } ctrlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;   // latch the user request fields
    logic issueRd;   // raise the read strobe next cycle
    logic issueWr;   // raise the write strobe next cycle
    logic captureRd; // latch read data and pulse valid
  } ctrlStrobes_t;

endpackage

// File: rtl/mgmt_access_seq.sv
module mgmt_access_seq
  import mgmt_access_pkg::*;
#(
  parameter int SETTLE_CYCLES  = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         initDone,
  input  logic         userReq,
  input  logic         userWrite,
  input  logic         rdAck,
  input  logic         wrAck,
  output logic         ifaceSel,
  output logic         userReady,
  output logic         busy,
  output logic         errTimeout,
  output ctrlStrobes_t strobes
);

  localparam int SETTLE_W  = (SETTLE_CYCLES  > 1) ? $clog2(SETTLE_CYCLES)  : 1;
  localparam int TIMEOUT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [SETTLE_W-1:0]  SETTLE_LAST  = SETTLE_W'(SETTLE_CYCLES - 1);
  localparam logic [TIMEOUT_W-1:0] TIMEOUT_LAST = TIMEOUT_W'(TIMEOUT_CYCLES - 1);

  ctrlState_t            state;
  logic [SETTLE_W-1:0]   settleCnt;
  logic [TIMEOUT_W-1:0]  waitCnt;
  logic                  accept;
  logic                  waitExpired;

  assign userReady   = (state == ST_IDLE) && initDone;
  assign accept      = userReady && userReq;
  assign busy        = (state == ST_READ_WAIT) || (state == ST_WRITE_WAIT);
  assign waitExpired = (waitCnt == TIMEOUT_LAST);

  always_comb begin
    strobes           = '0;
    strobes.loadReq   = accept;
    strobes.issueRd   = accept && !userWrite;
    strobes.issueWr   = accept && userWrite;
    strobes.captureRd = (state == ST_READ_WAIT) && rdAck;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RESET;
      ifaceSel   <= 1'b0;
      settleCnt  <= '0;
      waitCnt    <= '0;
      errTimeout <= 1'b0;
    end else begin
      unique case (state)
        ST_RESET: state <= ST_INIT_WAIT;
        ST_INIT_WAIT: begin
          if (initDone) begin
            ifaceSel  <= 1'b1;
            settleCnt <= '0;
            state     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (!initDone) begin
            ifaceSel <= 1'b0;
            state    <= ST_INIT_WAIT;
          end else if (settleCnt == SETTLE_LAST) begin
            state <= ST_IDLE;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (!initDone) begin
            ifaceSel <= 1'b0;
            state    <= ST_INIT_WAIT;
          end else if (accept) begin
            waitCnt <= '0;
            state   <= userWrite ? ST_WRITE_WAIT : ST_READ_WAIT;
          end
        end
        ST_READ_WAIT: begin
          if (rdAck) begin
            state <= ST_IDLE;
          end else if (waitExpired) begin
            errTimeout <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_WRITE_WAIT: begin
          if (wrAck) begin
            state <= ST_IDLE;
          end else if (waitExpired) begin
            errTimeout <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= ST_RESET;
      endcase
    end
  end

  // R1: select only rises after init-done was seen
  assert_sel_after_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ifaceSel) |-> $past(initDone));

  // R2: never ready while the reconfiguration port owns the bus
  assert_no_ready_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    userReady |-> ifaceSel);

  // R10: the error flag never drops outside reset
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(errTimeout) |-> errTimeout);

  // R5: no acceptance while an access is pending
  assert_no_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !userReady);

endmodule

// File: rtl/mgmt_access_dp.sv
module mgmt_access_dp
  import mgmt_access_pkg::*;
#(
  parameter int LANE_W = 4,
  parameter int MMD_W  = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [LANE_W-1:0] userLane,
  input  logic [MMD_W-1:0]  userMmd,
  input  logic [ADDR_W-1:0] userRegAddr,
  input  logic [DATA_W-1:0] userWrData,
  input  logic [DATA_W-1:0] mgmtRdData,
  output logic [LANE_W-1:0] mgmtLane,
  output logic [MMD_W-1:0]  mgmtMmd,
  output logic [ADDR_W-1:0] mgmtRegAddr,
  output logic [DATA_W-1:0] mgmtWrData,
  output logic              mgmtRdStrobe,
  output logic              mgmtWrStrobe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  // request field holding registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mgmtLane    <= '0;
      mgmtMmd     <= '0;
      mgmtRegAddr <= '0;
      mgmtWrData  <= '0;
    end else if (strobes.loadReq) begin
      mgmtLane    <= userLane;
      mgmtMmd     <= userMmd;
      mgmtRegAddr <= userRegAddr;
      if (strobes.issueWr) mgmtWrData <= userWrData;
    end
  end

  // single-cycle strobes and read return
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mgmtRdStrobe <= 1'b0;
      mgmtWrStrobe <= 1'b0;
      rdValid      <= 1'b0;
      rdData       <= '0;
    end else begin
      mgmtRdStrobe <= strobes.issueRd;
      mgmtWrStrobe <= strobes.issueWr;
      rdValid      <= strobes.captureRd;
      rdData       <= strobes.captureRd ? mgmtRdData : '0;
    end
  end

  // R3: read strobe lasts one cycle
  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mgmtRdStrobe |=> !mgmtRdStrobe);

  // R4: write strobe lasts one cycle and never overlaps a read strobe
  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mgmtWrStrobe |=> !mgmtWrStrobe);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mgmtRdStrobe && mgmtWrStrobe));

  // R6: data is zero whenever valid is low
  assert_rd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |-> (rdData == '0));

endmodule

// File: rtl/mgmt_access_ctrl.sv
module mgmt_access_ctrl
  import mgmt_access_pkg::*;
#(
  parameter int LANE_W         = 4,
  parameter int MMD_W          = 5,
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter int SETTLE_CYCLES  = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              initDone,
  output logic              ifaceSel,
  input  logic              userReq,
  input  logic              userWrite,
  input  logic [LANE_W-1:0] userLane,
  input  logic [MMD_W-1:0]  userMmd,
  input  logic [ADDR_W-1:0] userRegAddr,
  input  logic [DATA_W-1:0] userWrData,
  output logic              userReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              errTimeout,
  output logic [LANE_W-1:0] mgmtLane,
  output logic [MMD_W-1:0]  mgmtMmd,
  output logic [ADDR_W-1:0] mgmtRegAddr,
  output logic [DATA_W-1:0] mgmtWrData,
  output logic              mgmtRdStrobe,
  output logic              mgmtWrStrobe,
  input  logic              mgmtRdAck,
  input  logic              mgmtWrAck,
  input  logic [DATA_W-1:0] mgmtRdData
);

  ctrlStrobes_t strobes;
  logic         busy;

  mgmt_access_seq #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .initDone  (initDone),
    .userReq   (userReq),
    .userWrite (userWrite),
    .rdAck     (mgmtRdAck),
    .wrAck     (mgmtWrAck),
    .ifaceSel  (ifaceSel),
    .userReady (userReady),
    .busy      (busy),
    .errTimeout(errTimeout),
    .strobes   (strobes)
  );

  mgmt_access_dp #(
    .LANE_W(LANE_W),
    .MMD_W (MMD_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .userLane    (userLane),
    .userMmd     (userMmd),
    .userRegAddr (userRegAddr),
    .userWrData  (userWrData),
    .mgmtRdData  (mgmtRdData),
    .mgmtLane    (mgmtLane),
    .mgmtMmd     (mgmtMmd),
    .mgmtRegAddr (mgmtRegAddr),
    .mgmtWrData  (mgmtWrData),
    .mgmtRdStrobe(mgmtRdStrobe),
    .mgmtWrStrobe(mgmtWrStrobe),
    .rdValid     (rdValid),
    .rdData      (rdData)
  );

  // age of the current select value, saturating at 3
  logic       selPrev;
  logic [1:0] selAge;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selPrev <= 1'b0;
      selAge  <= 2'd3;
    end else begin
      selPrev <= ifaceSel;
      if (ifaceSel != selPrev) selAge <= 2'd0;
      else if (selAge != 2'd3) selAge <= selAge + 2'd1;
    end
  end

  // R2: two settling cycles after a select change before any strobe
  assert_settle_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmtRdStrobe || mgmtWrStrobe) |-> (selAge >= 2'd2));

  // R3/R4: every strobe follows an accepted request
  assert_strobe_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmtRdStrobe || mgmtWrStrobe) |-> $past(userReady && userReq));

  // R5: fields held while an access is pending
  assert_fields_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mgmtLane) && $stable(mgmtMmd) &&
                               $stable(mgmtRegAddr) && $stable(mgmtWrData)));

  // R6: read valid only after a read acknowledge
  assert_valid_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> $past(mgmtRdAck));

endmodule

// File: tb/test_mgmt_access_ctrl.sv
`timescale 1ns/1ps
module test_mgmt_access_ctrl;

  localparam int TO = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        initDone;
  logic        ifaceSel;
  logic        userReq, userWrite;
  logic [3:0]  userLane;
  logic [4:0]  userMmd;
  logic [15:0] userRegAddr, userWrData;
  logic        userReady, rdValid, errTimeout;
  logic [15:0] rdData;
  logic [3:0]  mgmtLane;
  logic [4:0]  mgmtMmd;
  logic [15:0] mgmtRegAddr, mgmtWrData, mgmtRdData;
  logic        mgmtRdStrobe, mgmtWrStrobe, mgmtRdAck, mgmtWrAck;

  int nCompared   = 0;
  int nMismatched = 0;
  bit finished    = 0;

  always #2.5 clk = ~clk;

  mgmt_access_ctrl #(.TIMEOUT_CYCLES(TO)) i_mgmt_access_ctrl (
    .clk(clk), .rst_n(rst_n), .initDone(initDone), .ifaceSel(ifaceSel),
    .userReq(userReq), .userWrite(userWrite), .userLane(userLane),
    .userMmd(userMmd), .userRegAddr(userRegAddr), .userWrData(userWrData),
    .userReady(userReady), .rdValid(rdValid), .rdData(rdData),
    .errTimeout(errTimeout), .mgmtLane(mgmtLane), .mgmtMmd(mgmtMmd),
    .mgmtRegAddr(mgmtRegAddr), .mgmtWrData(mgmtWrData),
    .mgmtRdStrobe(mgmtRdStrobe), .mgmtWrStrobe(mgmtWrStrobe),
    .mgmtRdAck(mgmtRdAck), .mgmtWrAck(mgmtWrAck), .mgmtRdData(mgmtRdData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // responder register model: data the transceiver returns for an address
  function automatic logic [15:0] respData(logic [3:0] lane, logic [4:0] mmd,
                                           logic [15:0] addr);
    return (addr * 16'd7) ^ {lane, mmd, 7'h35};
  endfunction

  task automatic waitReady();
    while (!userReady) @(negedge clk);
  endtask

  // one full access with the acknowledge after lat wait cycles
  task automatic doAccess(bit wr, logic [3:0] lane, logic [4:0] mmd,
                          logic [15:0] addr, logic [15:0] wd, int lat);
    logic [15:0] expRd;
    waitReady();
    userReq = 1'b1; userWrite = wr; userLane = lane; userMmd = mmd;
    userRegAddr = addr; userWrData = wd;
    @(negedge clk);
    userReq = 1'b0;
    userLane = ~lane; userMmd = ~mmd; userRegAddr = ~addr; userWrData = ~wd;
    if (wr) begin
      check(mgmtWrStrobe == 1'b1 && mgmtRdStrobe == 1'b0, "R4 write strobe",
            {mgmtRdStrobe, mgmtWrStrobe}, 32'b01);
      check(mgmtWrData == wd, "R4 write data", mgmtWrData, wd);
    end else begin
      check(mgmtRdStrobe == 1'b1 && mgmtWrStrobe == 1'b0, "R3 read strobe",
            {mgmtRdStrobe, mgmtWrStrobe}, 32'b10);
    end
    check({mgmtLane, mgmtMmd, mgmtRegAddr} == {lane, mmd, addr}, "R3 fields",
          {mgmtLane, mgmtMmd, mgmtRegAddr}, {lane, mmd, addr});
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(!mgmtRdStrobe && !mgmtWrStrobe && !userReady && !rdValid,
            "R5 pending quiet", {mgmtRdStrobe, mgmtWrStrobe, userReady, rdValid}, 0);
      check({mgmtLane, mgmtMmd, mgmtRegAddr} == {lane, mmd, addr}, "R5 held",
            {mgmtLane, mgmtMmd, mgmtRegAddr}, {lane, mmd, addr});
    end
    expRd = respData(lane, mmd, addr);
    if (wr) mgmtWrAck = 1'b1;
    else begin mgmtRdAck = 1'b1; mgmtRdData = expRd; end
    @(negedge clk);
    mgmtWrAck = 1'b0; mgmtRdAck = 1'b0; mgmtRdData = 16'h0;
    if (wr) begin
      check(!rdValid && userReady, "R7 write done", {rdValid, userReady}, 32'b01);
    end else begin
      check(rdValid && userReady, "R6 read done", {rdValid, userReady}, 32'b11);
      check(rdData == expRd, "R6 read data", rdData, expRd);
    end
  endtask

  task automatic settleCheck();
    initDone = 1'b1;
    @(negedge clk);
    check(ifaceSel == 1'b1, "R1 select rises", ifaceSel, 1);
    check(!userReady, "R2 settle 0", userReady, 0);
    @(negedge clk);
    check(!userReady, "R2 settle 1", userReady, 0);
    @(negedge clk);
    check(userReady, "R2 ready after settle", userReady, 1);
  endtask

  initial begin
    rst_n = 1'b0; initDone = 1'b0; userReq = 1'b0; userWrite = 1'b0;
    userLane = '0; userMmd = '0; userRegAddr = '0; userWrData = '0;
    mgmtRdAck = 1'b0; mgmtWrAck = 1'b0; mgmtRdData = '0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({ifaceSel, userReady, mgmtRdStrobe, mgmtWrStrobe, rdValid, errTimeout} == 0,
          "R2 reset state", {ifaceSel, userReady, mgmtRdStrobe, mgmtWrStrobe, rdValid, errTimeout}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!ifaceSel && !userReady, "R1 held low in init", {ifaceSel, userReady}, 0);
    end
    settleCheck();

    doAccess(0, 4'h3, 5'h01, 16'h0000, 16'h0, 0);
    @(negedge clk);
    check(!rdValid && rdData == 0, "R6 zero outside ack", {rdValid, rdData}, 0);
    doAccess(1, 4'hF, 5'h1F, 16'hFFFF, 16'hA5C3, 3);
    doAccess(0, 4'h0, 5'h1E, 16'h8001, 16'h0, 7);

    // stray acknowledges while idle
    mgmtRdAck = 1'b1; mgmtRdData = 16'hBEEF;
    @(negedge clk);
    mgmtRdAck = 1'b0; mgmtRdData = 16'h0;
    check(!rdValid && rdData == 0 && userReady, "R9 stray read ack",
          {rdValid, rdData, userReady}, 1);
    mgmtWrAck = 1'b1;
    @(negedge clk);
    mgmtWrAck = 1'b0;
    check(!rdValid && userReady, "R9 stray write ack", {rdValid, userReady}, 1);

    // mismatched ack during a pending read
    userReq = 1'b1; userWrite = 1'b0; userLane = 4'h5; userMmd = 5'h3; userRegAddr = 16'h1234;
    @(negedge clk);
    userReq = 1'b0;
    mgmtWrAck = 1'b1;
    @(negedge clk);
    mgmtWrAck = 1'b0;
    check(!userReady && !rdValid, "R9 mismatched ack", {userReady, rdValid}, 0);
    mgmtRdAck = 1'b1; mgmtRdData = respData(4'h5, 5'h3, 16'h1234);
    @(negedge clk);
    mgmtRdAck = 1'b0; mgmtRdData = 16'h0;
    check(rdValid && rdData == respData(4'h5, 5'h3, 16'h1234), "R6 after mismatch",
          rdData, respData(4'h5, 5'h3, 16'h1234));

    // init-done drops while idle, then returns
    initDone = 1'b0;
    @(negedge clk);
    check(!ifaceSel && !userReady, "R1 select falls", {ifaceSel, userReady}, 0);
    @(negedge clk);
    settleCheck();

    // constrained random traffic
    for (int n = 0; n < 60; n++) begin
      doAccess(1'($urandom_range(0, 1)), 4'($urandom), 5'($urandom), 16'($urandom),
               16'($urandom), int'($urandom_range(0, 10)));
    end

    // timeout
    waitReady();
    userReq = 1'b1; userWrite = 1'b0; userLane = 4'h9; userMmd = 5'h7; userRegAddr = 16'h00C0;
    @(negedge clk);
    userReq = 1'b0;
    check(mgmtRdStrobe, "R3 strobe before timeout", mgmtRdStrobe, 1);
    for (int i = 1; i < TO; i++) begin
      @(negedge clk);
      if (userReady || errTimeout)
        check(0, "R8 early abort", {userReady, errTimeout}, 0);
    end
    check(!userReady && !errTimeout, "R8 still pending", {userReady, errTimeout}, 0);
    @(negedge clk);
    check(userReady && errTimeout && !rdValid, "R8 abort", {userReady, errTimeout, rdValid}, 3'b110);
    mgmtRdAck = 1'b1; mgmtRdData = 16'h7777;
    @(negedge clk);
    mgmtRdAck = 1'b0; mgmtRdData = 16'h0;
    check(!rdValid && rdData == 0, "R9 late ack", {rdValid, rdData}, 0);
    doAccess(1, 4'h1, 5'h2, 16'h0003, 16'h0004, 2);
    check(errTimeout, "R10 error sticky", errTimeout, 1);

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!errTimeout, "R10 reset clears", errTimeout, 0);
    rst_n = 1'b1;
    doAccess(0, 4'h2, 5'h4, 16'h0042, 16'h0, 1);
    check(!errTimeout, "R10 stays clear", errTimeout, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

endmodule